// File: doc/BRIEF.md
# Windowed Fractional Segment Tally with Threshold Release

This block counts how often each road segment is used during one time window, where one traveller may be spread across several plausible routes. A traveller is announced by a command that carries the number of candidate routes `h`. The block turns that count into a weight of 1/h in Q16.16 fixed point with a short sequential divider. Every segment identifier that follows is then added to that segment's counter in on-chip memory, using the current weight. A traveller with a single route, whether `h` is 1 or 0, adds a full 1.0 to each segment of that route.

A close command ends the window and carries an integer threshold `k`. The block then walks every counter in ascending identifier order. It emits the identifier of each counter whose value is at least k, zeroes every counter, and signals when the walk is over. Segments below the threshold are never shown at the output. Commands are refused while the divider runs, while the walk runs, and while the memory is cleared after reset.

The controller has five states. ST_INIT clears memory after reset and moves to ST_OPEN once the last entry has been written. ST_OPEN accepts commands: a traveller command moves to ST_DIV, a close command moves to ST_SCAN, and segment or no-op commands stay in ST_OPEN. ST_DIV returns to ST_OPEN when the divider finishes. ST_SCAN moves to ST_DRAIN after the last identifier has been read. ST_DRAIN returns to ST_OPEN after one cycle.

Top module: `seg_tally_release`

## Requirements
- R1: After reset every counter reads zero. `cmd_ready` stays low for exactly 2^IDW cycles while memory is cleared, and `rel_valid` and `window_done` are low.
- R2: A command is taken on a clock edge where `cmd_valid` and `cmd_ready` are both high. `cmd_kind` 2'b00 is a segment with the identifier in the low IDW bits of `cmd_data`. 2'b01 is a traveller with h in the low HW bits. 2'b10 is a close with k in the low KW bits. 2'b11 is accepted and has no effect on any counter.
- R3: The traveller weight is floor(2^16 / h) in Q16.16, and h of 0 or 1 gives 1.0. Until the first traveller command after reset, the weight is 1.0.
- R4: After a traveller command is taken, `cmd_ready` is low for exactly QF+1 cycles while the weight is computed.
- R5: Each accepted segment adds the current weight to its counter. Segments sent on back-to-back cycles to the same identifier all count.
- R6: A counter saturates at 32'hFFFFFFFF and never wraps.
- R7: After a close, identifiers are emitted in ascending order, one per `rel_valid` cycle, exactly for those counters with value >= k·2^16. The value of k is taken at the close command.
- R8: The walk zeroes every counter, so the next window starts from zero.
- R9: After a close is taken, `cmd_ready` is low for exactly 2^IDW+1 cycles. `window_done` is a one-cycle pulse in the cycle `cmd_ready` returns high.
- R10: `rel_valid` is asserted only during the walk, never outside it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present |
| cmd_kind | input | 2 | Command type (segment, traveller, close, no-op) |
| cmd_data | input | DW | Identifier, h or k, depending on the command type |
| cmd_ready | output | 1 | Command can be taken this cycle |
| rel_valid | output | 1 | A released identifier is present |
| rel_id | output | IDW | Released segment identifier |
| window_done | output | 1 | Pulse marking the end of the walk |

## Verification
The bench sends many segments to one identifier on consecutive cycles. A design that lost the forwarded read-modify-write result would then under-count and drop releases. It sends more than 65536 full-weight hits to one counter: a wrapping accumulator would fall back to a small value and fail to release at k = 65535. Three travellers with h = 3 on one segment leave the counter just below 1.0, so a rounding-up divider would wrongly release that segment at k = 1. A k of zero must release every identifier. A window after a walk must release nothing, which catches a walk that does not clear. The stall lengths after traveller and close commands are counted, which catches off-by-one sequencing in the state machine.

// File: rtl/seg_tally_pkg.sv
package seg_tally_pkg;

    typedef enum logic [2:0] {
        ST_INIT  = 3'd0,
        ST_OPEN  = 3'd1,
        ST_DIV   = 3'd2,
        ST_SCAN  = 3'd3,
        ST_DRAIN = 3'd4
    } tally_state_t;

    typedef enum logic [1:0] {
        CMD_SEG   = 2'b00,
        CMD_USER  = 2'b01,
        CMD_CLOSE = 2'b10,
        CMD_NOP   = 2'b11
    } cmd_kind_t;

endpackage

// File: rtl/seg_tally_ram.sv
module seg_tally_ram #(
    parameter int AW = 6,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    // Read returns the value held before a same-edge write.
    always_ff @(posedge clk) begin
        rdata <= mem[raddr];
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

endmodule

// File: rtl/seg_recip_div.sv
module seg_recip_div #(
    parameter int HW = 8,
    parameter int QF = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [HW-1:0] h,
    output logic          busy,
    output logic          done,
    output logic [QF:0]   quot
);
    localparam int CNTW = $clog2(QF + 1);

    logic [HW-1:0] div_q;
    logic [HW:0]   rem_q;
    logic [QF:0]   q_q;
    logic [CNTW-1:0] cnt_q;

    logic          bit_in;
    logic [HW:0]   rem_sh;
    logic          ge;
    logic [HW:0]   rem_nx;
    logic [QF:0]   q_nx;

    // Dividend is 1 << QF: only the first bit brought down is a one.
    always_comb begin
        bit_in = (cnt_q == '0);
        rem_sh = {rem_q[HW-1:0], bit_in};
        ge     = (rem_sh >= {1'b0, div_q});
        rem_nx = ge ? (rem_sh - {1'b0, div_q}) : rem_sh;
        q_nx   = {q_q[QF-1:0], ge};
    end

    assign done = busy && (cnt_q == CNTW'(QF));
    assign quot = q_nx;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy  <= 1'b0;
            div_q <= '0;
            rem_q <= '0;
            q_q   <= '0;
            cnt_q <= '0;
        end else if (start) begin
            busy  <= 1'b1;
            div_q <= h;
            rem_q <= '0;
            q_q   <= '0;
            cnt_q <= '0;
        end else if (busy) begin
            rem_q <= rem_nx;
            q_q   <= q_nx;
            cnt_q <= cnt_q + 1'b1;
            if (done) begin
                busy <= 1'b0;
            end
        end
    end

    // R4: a started division is running on the next cycle
    p_div_starts_r4: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> busy);

    // R3: the weight is never zero and never above 1.0
    p_weight_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (quot != '0 && quot <= (QF+1)'(1 << QF)));

endmodule

// File: rtl/seg_tally_release.sv
module seg_tally_release
    import seg_tally_pkg::*;
#(
    parameter int IDW = 6,
    parameter int HW  = 8,
    parameter int KW  = 16,
    parameter int QF  = 16,
    parameter int CW  = 32,
    parameter int DW  = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cmd_valid,
    input  logic [1:0]     cmd_kind,
    input  logic [DW-1:0]  cmd_data,
    output logic           cmd_ready,
    output logic           rel_valid,
    output logic [IDW-1:0] rel_id,
    output logic           window_done
);
    localparam int          DEPTH = 1 << IDW;
    localparam logic [IDW-1:0] LAST_ID = IDW'(DEPTH - 1);
    localparam logic [CW-1:0]  CMAX  = {CW{1'b1}};
    localparam logic [CW-1:0]  ONE   = CW'(1) << QF;

    tally_state_t state_q, state_d;

    logic [IDW-1:0] ptr_q;
    logic [CW-1:0]  weight_q;
    logic [CW-1:0]  kthr_q;

    logic           accept, seg_go, user_go, close_go;
    logic [HW-1:0]  h_in;
    logic           div_busy, div_done;
    logic [QF:0]    div_quot;

    logic [IDW-1:0] raddr;
    logic [CW-1:0]  rd_data;
    logic           we;
    logic [IDW-1:0] waddr;
    logic [CW-1:0]  wdata;

    logic           s1_valid, s1_scan;
    logic [IDW-1:0] s1_addr;
    logic [CW-1:0]  s1_w;

    logic           fw_valid;
    logic [IDW-1:0] fw_addr;
    logic [CW-1:0]  fw_data;

    logic [CW-1:0]  old_val;
    logic [CW:0]    sum;
    logic [CW-1:0]  new_val;
    logic           hit;

    logic           rel_valid_q, done_q;
    logic [IDW-1:0] rel_id_q;

    // command decode
    assign cmd_ready = (state_q == ST_OPEN);
    assign accept    = cmd_valid && cmd_ready;
    assign seg_go    = accept && (cmd_kind == CMD_SEG);
    assign user_go   = accept && (cmd_kind == CMD_USER);
    assign close_go  = accept && (cmd_kind == CMD_CLOSE);
    assign h_in      = (cmd_data[HW-1:0] == '0) ? HW'(1) : cmd_data[HW-1:0];

    seg_recip_div #(.HW(HW), .QF(QF)) div_i (
        .clk   (clk),
        .rst_n (rst_n),
        .start (user_go),
        .h     (h_in),
        .busy  (div_busy),
        .done  (div_done),
        .quot  (div_quot)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_INIT:  if (ptr_q == LAST_ID) state_d = ST_OPEN;
            ST_OPEN: begin
                if (user_go)       state_d = ST_DIV;
                else if (close_go) state_d = ST_SCAN;
            end
            ST_DIV:   if (div_done) state_d = ST_OPEN;
            ST_SCAN:  if (ptr_q == LAST_ID) state_d = ST_DRAIN;
            ST_DRAIN: state_d = ST_OPEN;
            default:  state_d = ST_INIT;
        endcase
    end

    // state register and sequencing registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_INIT;
            ptr_q    <= '0;
            weight_q <= ONE;
            kthr_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_INIT || state_q == ST_SCAN) begin
                ptr_q <= ptr_q + 1'b1;
            end else if (close_go) begin
                ptr_q <= '0;
            end
            if (div_done) begin
                weight_q <= CW'(div_quot);
            end
            if (close_go) begin
                kthr_q <= CW'(cmd_data[KW-1:0]) << QF;
            end
        end
    end

    // counter memory and its read-modify-write stage
    assign raddr = (state_q == ST_SCAN) ? ptr_q : cmd_data[IDW-1:0];

    always_comb begin
        old_val = (fw_valid && fw_addr == s1_addr) ? fw_data : rd_data;
        sum     = {1'b0, old_val} + {1'b0, s1_w};
        new_val = sum[CW] ? CMAX : sum[CW-1:0];
        hit     = s1_valid && s1_scan && (old_val >= kthr_q);
        if (state_q == ST_INIT) begin
            we    = 1'b1;
            waddr = ptr_q;
            wdata = '0;
        end else begin
            we    = s1_valid;
            waddr = s1_addr;
            wdata = s1_scan ? '0 : new_val;
        end
    end

    seg_tally_ram #(.AW(IDW), .DW(CW)) ram_i (
        .clk   (clk),
        .raddr (raddr),
        .rdata (rd_data),
        .we    (we),
        .waddr (waddr),
        .wdata (wdata)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid <= 1'b0;
            s1_scan  <= 1'b0;
            s1_addr  <= '0;
            s1_w     <= '0;
            fw_valid <= 1'b0;
            fw_addr  <= '0;
            fw_data  <= '0;
        end else begin
            s1_valid <= seg_go || (state_q == ST_SCAN);
            s1_scan  <= (state_q == ST_SCAN);
            s1_addr  <= raddr;
            s1_w     <= weight_q;
            fw_valid <= s1_valid;
            fw_addr  <= s1_addr;
            fw_data  <= wdata;
        end
    end

    // output register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rel_valid_q <= 1'b0;
            rel_id_q    <= '0;
            done_q      <= 1'b0;
        end else begin
            rel_valid_q <= hit;
            rel_id_q    <= s1_addr;
            done_q      <= (state_q == ST_DRAIN);
        end
    end

    assign rel_valid   = rel_valid_q;
    assign rel_id      = rel_id_q;
    assign window_done = done_q;

    // R6: an accumulated counter never drops below its previous value
    p_no_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_valid && !s1_scan) |-> (wdata >= old_val));

    // R10: releases come only from the walk
    p_rel_in_walk_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rel_valid |-> ($past(state_q) == ST_SCAN || $past(state_q) == ST_DRAIN));

    // R9: the end pulse lasts one cycle
    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        window_done |=> !window_done);

    // R9: commands are open again when the end pulse appears
    p_open_at_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
        window_done |-> cmd_ready);

endmodule

// File: tb/seg_tally_release_tb.sv
`timescale 1ns/1ps
module seg_tally_release_tb_top;
    localparam int IDW   = 6;
    localparam int DEPTH = 1 << IDW;
    localparam int QF    = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd_valid = 1'b0;
    logic [1:0] cmd_kind = 2'b00;
    logic [15:0] cmd_data = '0;
    logic cmd_ready, rel_valid, window_done;
    logic [IDW-1:0] rel_id;

    always #2 clk = ~clk;

    seg_tally_release dut_i (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_kind(cmd_kind),
        .cmd_data(cmd_data), .cmd_ready(cmd_ready), .rel_valid(rel_valid),
        .rel_id(rel_id), .window_done(window_done)
    );

    int errors = 0;
    int checks = 0;
    bit finished = 0;
    int exp_q[$];
    longint model [DEPTH];
    longint cur_w = 65536;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n) begin
            if (rel_valid) begin
                if (exp_q.size() == 0) begin
                    chk(0, "R10 unexpected release", rel_id, -1);
                end else begin
                    int e;
                    e = exp_q.pop_front();
                    chk(rel_id == e, "R7 released id", rel_id, e);
                end
            end
            if (window_done) begin
                chk(exp_q.size() == 0, "R7 missing releases at window end", exp_q.size(), 0);
            end
        end
    end

    // caller is at a negedge; returns at the negedge after acceptance
    task automatic send(input logic [1:0] kind, input int data);
        if (kind == 2'b01) begin
            cur_w = (data < 2) ? 65536 : (65536 / data);
        end else if (kind == 2'b00) begin
            longint t;
            t = model[data] + cur_w;
            model[data] = (t > 64'hFFFFFFFF) ? 64'hFFFFFFFF : t;
        end
        cmd_valid = 1'b1;
        cmd_kind  = kind;
        cmd_data  = 16'(data);
        while (!cmd_ready) @(negedge clk);
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic user(input int h);
        int n = 0;
        send(2'b01, h);
        while (!cmd_ready) begin n++; @(negedge clk); end
        chk(n == QF + 1, "R4 divide stall cycles", n, QF + 1);
    endtask

    task automatic close_window(input int k);
        int n = 0;
        for (int i = 0; i < DEPTH; i++) begin
            if (model[i] >= (longint'(k) << 16)) exp_q.push_back(i);
            model[i] = 0;
        end
        send(2'b10, k);
        while (!cmd_ready) begin n++; @(negedge clk); end
        chk(n == DEPTH + 1, "R9 walk stall cycles", n, DEPTH + 1);
        chk(window_done == 1'b1, "R9 end pulse with ready", window_done, 1);
        @(negedge clk);
        chk(window_done == 1'b0, "R9 end pulse one cycle", window_done, 0);
    endtask

    initial begin
        for (int i = 0; i < DEPTH; i++) model[i] = 0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        begin
            int n = 0;
            chk(rel_valid == 0 && window_done == 0, "R1 outputs idle after reset", rel_valid, 0);
            while (!cmd_ready) begin n++; @(negedge clk); end
            chk(n == DEPTH, "R1 clear stall cycles", n, DEPTH);
        end
        // R1: memory cleared, empty window releases nothing
        close_window(1);

        // R3: default weight 1.0 before any traveller; R7 threshold
        send(2'b00, 3); send(2'b00, 3); send(2'b00, 7);
        close_window(2);

        // R3 weights from h: two routes per traveller
        for (int u = 0; u < 4; u++) begin
            user(2);
            send(2'b00, 20);
            send(2'b00, 21); send(2'b00, 22);
        end
        close_window(2);

        // R3 truncation: 3 x floor(65536/3) stays below 1.0; h=0 gives 1.0
        for (int u = 0; u < 3; u++) begin
            user(3);
            send(2'b00, 30);
        end
        user(0);
        send(2'b00, 40);
        user(5);
        send(2'b00, 41);
        close_window(1);

        // R5 back-to-back updates of one identifier
        user(1);
        for (int i = 0; i < 5; i++) send(2'b00, 50);
        send(2'b00, 51); send(2'b00, 50);
        close_window(6);

        // R2 no-op kind leaves counters untouched
        send(2'b00, 5);
        send(2'b11, 5); send(2'b11, 5);
        close_window(2);

        // R7 with k = 0 releases every identifier
        close_window(0);
        // R8 walk cleared everything
        close_window(0 + 1);

        // R6 saturation rather than wrap
        for (int i = 0; i < 65539; i++) send(2'b00, 63);
        close_window(65535);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule